// File: doc/BRIEF.md
# I2C Master Clock Generator with Stretch Tolerance

This block produces the serial clock of an I2C master on an open-drain line. It never drives the line high. It either enables a pull-down or lets the line float, and it reads the real line level back through a two-flop synchronizer. After the pull-down is let go, the block waits until the line is actually seen high before it counts the high phase. A slave that slows the transfer by holding the clock low is therefore treated as a stall and not as a fault. A competing master that pulls the line low early cuts the high phase short.

The low and high phase lengths are counted in system clocks and set through two divider inputs. A data shifter nearby uses three single-cycle strobes. One marks the falling edge, where data may change. One marks the rising edge. One marks the middle of the high phase, where data is sampled. A status output reports the line being low while the generator wants it high. The same output also reports the generator holding the line low on request of the shifter. An optional timeout raises a sticky error when the released line stays low too long.

Top module: `scl_gen`

## Requirements
- R1: While rst_ni is low, scl_pd_o, all three strobes, and stall_err_o are 0. scl_low_o is also 0 while scl_i is high. The synchronizer resets to the high level.
- R2: scl_i reaches every decision only through two flops. If a released and stalled line goes high before clock edge E1, rise_stb_o is 1 in the cycle after edge E3 and not before.
- R3: With run_i high, each low phase enables the pull-down for max(lo_div_i,1) cycles when hold_i is 0.
- R4: After release, the high phase starts on the first cycle in which the synchronized line is high. Its length is max(hi_div_i,1) cycles. An external hold of any length only delays it and sets no error unless the timeout is armed.
- R5: fall_stb_o is 1 for exactly one cycle, the first cycle of each low phase. rise_stb_o is 1 for the first cycle of each high phase. mid_stb_o is 1 at high-phase cycle index floor(max(hi_div_i,1)/2), counting from 0.
- R6: A synchronized low seen during the high phase ends that phase at once. The next state is a low phase if run_i is high and idle otherwise.
- R7: scl_low_o is 1 in every cycle in which the pull-down is off and the synchronized line is low.
- R8: If hold_i is high when the low phase has used up its count, the pull-down stays on and scl_low_o is 1 until hold_i falls.
- R9: With run_i low at the end of a high phase, the block goes idle and keeps the pull-down off with no strobes.
- R10: The timeout is armed when tmo_en_i is high and tmo_lim_i is nonzero. While armed, stall_err_o rises once the released line has been low in the synchronized view for tmo_lim_i consecutive cycles. It then stays high.
- R11: stall_err_o clears when a run starts from idle, that is, run_i is high while idle. This clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request to generate clock periods |
| hold_i | input | 1 | Extend the low phase (shifter not ready) |
| lo_div_i | input | DIV_W | Low phase length in system clocks |
| hi_div_i | input | DIV_W | High phase length in system clocks |
| tmo_en_i | input | 1 | Arm the stall timeout |
| tmo_lim_i | input | TMO_W | Stall timeout limit in system clocks |
| scl_i | input | 1 | Raw level of the clock line |
| scl_pd_o | output | 1 | Pull-down enable for the clock line |
| rise_stb_o | output | 1 | First cycle of the high phase |
| mid_stb_o | output | 1 | Sample point in the high phase |
| fall_stb_o | output | 1 | First cycle of the low phase |
| scl_low_o | output | 1 | Line low while the block wants it high, or held low on request |
| stall_err_o | output | 1 | Sticky stall timeout error |

## Verification
Two functions can fall in the same cycle. The first is the timeout setting the stall error. The second is a new run from idle clearing that error. The bench provokes this coincidence with a constrained random phase. In that phase random external holds, short timeout limits and frequent toggles of run_i overlap, so the bus sits idle and low just as a run begins. A second overlap is also exercised there: an external early low that ends a high phase can land in the same cycle as the natural end of the high count. A cycle-exact reference model in the bench judges every cycle. The model lets the clear win and treats both ends of the high phase as one transition, so only one falling strobe may follow.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_ph_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] lo_div_i,
  input  logic [DIV_W-1:0] hi_div_i,
  input  logic             scl_s_i,
  output logic             pd_o,
  output logic             rise_o,
  output logic             mid_o,
  output logic             fall_o,
  output logic             low_done_o,
  output logic             run_start_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  scl_ph_e          st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lo_len, hi_len;
  logic             last_lo, last_hi;
  logic             rise_q, fall_q;

  assign lo_len  = (lo_div_i == '0) ? ONE : lo_div_i;
  assign hi_len  = (hi_div_i == '0) ? ONE : hi_div_i;
  assign last_lo = cnt_q >= (lo_len - ONE);
  assign last_hi = cnt_q >= (hi_len - ONE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_IDLE: if (run_i) begin
        st_d  = PH_LOW;
        cnt_d = '0;
      end
      PH_LOW: begin
        if (!last_lo) cnt_d = cnt_q + ONE;
        else if (!hold_i) begin
          st_d  = PH_WAIT;
          cnt_d = '0;
        end
      end
      // released; stall until line seen high
      PH_WAIT: if (scl_s_i) begin
        st_d  = PH_HIGH;
        cnt_d = '0;
      end
      PH_HIGH: begin
        if (!scl_s_i || last_hi) begin
          st_d  = run_i ? PH_LOW : PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rise_q <= (st_d == PH_HIGH) && (st_q != PH_HIGH);
      fall_q <= (st_d == PH_LOW)  && (st_q != PH_LOW);
    end
  end

  assign pd_o        = (st_q == PH_LOW);
  assign rise_o      = rise_q;
  assign fall_o      = fall_q;
  assign mid_o       = (st_q == PH_HIGH) && (cnt_q == (hi_len >> 1));
  assign low_done_o  = (st_q == PH_LOW) && last_lo;
  assign run_start_o = (st_q == PH_IDLE) && run_i;
endmodule

// File: rtl/scl_tmo_mon.sv
module scl_tmo_mon #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMO_W-1:0] lim_i,
  input  logic             ext_low_i,
  input  logic             clr_i,
  output logic             err_o
);
  localparam logic [TMO_W-1:0] ONE = {{(TMO_W-1){1'b0}}, 1'b1};

  logic [TMO_W-1:0] run_q;
  logic             err_q, hit;

  assign hit = en_i && (lim_i != '0) && ext_low_i && (run_q >= lim_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!ext_low_i)        run_q <= '0;
      else if (~&run_q)      run_q <= run_q + ONE;
      if (clr_i)             err_q <= 1'b0;
      else if (hit)          err_q <= 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] lo_div_i,
  input  logic [DIV_W-1:0] hi_div_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             scl_i,
  output logic             scl_pd_o,
  output logic             rise_stb_o,
  output logic             mid_stb_o,
  output logic             fall_stb_o,
  output logic             scl_low_o,
  output logic             stall_err_o
);
  logic scl_s, pd, low_done, run_start, ext_low;

  scl_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .hold_i     (hold_i),
    .lo_div_i   (lo_div_i),
    .hi_div_i   (hi_div_i),
    .scl_s_i    (scl_s),
    .pd_o       (pd),
    .rise_o     (rise_stb_o),
    .mid_o      (mid_stb_o),
    .fall_o     (fall_stb_o),
    .low_done_o (low_done),
    .run_start_o(run_start)
  );

  // released but seen low: stretch or another master
  assign ext_low = !pd && !scl_s;

  scl_tmo_mon #(.TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tmo_en_i),
    .lim_i    (tmo_lim_i),
    .ext_low_i(ext_low),
    .clr_i    (run_start),
    .err_o    (stall_err_o)
  );

  assign scl_pd_o  = pd;
  assign scl_low_o = ext_low || (low_done && hold_i);
endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic scl_pd_o,
  input logic rise_stb_o,
  input logic mid_stb_o,
  input logic fall_stb_o,
  input logic scl_low_o,
  input logic stall_err_o,
  input logic scl_s_i
);
  a_r5_fall_on_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pd_o) |-> fall_stb_o);

  a_r3_fall_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> scl_pd_o);

  a_r5_edges_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_stb_o, fall_stb_o}));

  a_r5_mid_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_stb_o |-> !scl_pd_o);

  a_r4_rise_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |-> ($past(scl_s_i) && !scl_pd_o));

  a_r7_flag_ext_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_pd_o && !scl_s_i) |-> scl_low_o);

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_err_o && !run_i) |=> stall_err_o);
endmodule

bind scl_gen scl_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .scl_pd_o   (scl_pd_o),
  .rise_stb_o (rise_stb_o),
  .mid_stb_o  (mid_stb_o),
  .fall_stb_o (fall_stb_o),
  .scl_low_o  (scl_low_o),
  .stall_err_o(stall_err_o),
  .scl_s_i    (scl_s)
);

// File: tb/scl_gen_tb.sv
module scl_gen_tb;
  localparam int DW   = 8;
  localparam int TW   = 8;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni, run_i, hold_i, tmo_en_i, scl_i;
  logic [DW-1:0] lo_div_i, hi_div_i;
  logic [TW-1:0] tmo_lim_i;
  logic          scl_pd_o, rise_stb_o, mid_stb_o, fall_stb_o, scl_low_o, stall_err_o;

  scl_gen #(.DIV_W(DW), .TMO_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .hold_i(hold_i),
    .lo_div_i(lo_div_i), .hi_div_i(hi_div_i), .tmo_en_i(tmo_en_i),
    .tmo_lim_i(tmo_lim_i), .scl_i(scl_i), .scl_pd_o(scl_pd_o),
    .rise_stb_o(rise_stb_o), .mid_stb_o(mid_stb_o), .fall_stb_o(fall_stb_o),
    .scl_low_o(scl_low_o), .stall_err_o(stall_err_o)
  );

  int total = 0, bad = 0;
  // reference model state: 0 idle, 1 low, 2 wait, 3 high
  int m_st, m_cnt, m_tcnt;
  bit m_s1, m_s2, m_rise, m_fall, m_err;
  // requested and applied stimulus
  bit g_run, g_hold, g_ext, g_ten, rnd_ext;
  int g_lo, g_hi, g_lim, ext_cnt;
  bit a_hold;
  int a_lo, a_hi;

  function automatic int len(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit exp_low_flag();
    return ((m_st != 1) && !m_s2) || ((m_st == 1) && (m_cnt >= len(a_lo) - 1) && a_hold);
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit line);
    int nst, ncnt;
    bit ext_low, set, rs;
    nst = m_st; ncnt = m_cnt;
    case (m_st)
      0: if (g_run) begin nst = 1; ncnt = 0; end
      1: if (m_cnt >= len(g_lo) - 1) begin
           if (!g_hold) begin nst = 2; ncnt = 0; end
         end else ncnt = m_cnt + 1;
      2: if (m_s2) begin nst = 3; ncnt = 0; end
      default: if (!m_s2 || m_cnt >= len(g_hi) - 1) begin
           nst = g_run ? 1 : 0; ncnt = 0;
         end else ncnt = m_cnt + 1;
    endcase
    rs      = (m_st == 0) && g_run;
    ext_low = (m_st != 1) && !m_s2;
    set     = g_ten && (g_lim != 0) && ext_low && (m_tcnt >= g_lim - 1);
    m_err   = rs ? 1'b0 : (m_err | set);
    m_tcnt  = ext_low ? ((m_tcnt < TMAX) ? m_tcnt + 1 : m_tcnt) : 0;
    m_rise  = (nst == 3) && (m_st != 3);
    m_fall  = (nst == 1) && (m_st != 1);
    m_s2 = m_s1; m_s1 = line;
    m_st = nst; m_cnt = ncnt;
  endtask

  task automatic apply_step();
    run_i     = g_run;
    hold_i    = g_hold;
    lo_div_i  = DW'(g_lo);
    hi_div_i  = DW'(g_hi);
    tmo_en_i  = g_ten;
    tmo_lim_i = TW'(g_lim);
    scl_i     = (m_st != 1) && !g_ext;
    a_hold = g_hold; a_lo = g_lo; a_hi = g_hi;
    step(scl_i);
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(scl_pd_o,    m_st == 1, "R3 pd");
    chk(rise_stb_o,  m_rise,    "R5 rise");
    chk(fall_stb_o,  m_fall,    "R5 fall");
    chk(mid_stb_o,   (m_st == 3) && (m_cnt == (len(a_hi) >> 1)), "R5 mid");
    chk(scl_low_o,   exp_low_flag(), "R7 R8 flag");
    chk(stall_err_o, m_err,     "R10 err");
    if (rnd_ext) begin
      if (ext_cnt > 0) ext_cnt--;
      else if ($urandom % 16 == 0) ext_cnt = 1 + $urandom % 12;
      g_ext = (ext_cnt > 0);
    end
    apply_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit prev;
    void'($urandom(32'd4711));
    g_run = 0; g_hold = 0; g_ext = 0; g_ten = 0; g_lo = 3; g_hi = 5; g_lim = 0;
    rnd_ext = 0; ext_cnt = 0;
    m_st = 0; m_cnt = 0; m_tcnt = 0; m_s1 = 1; m_s2 = 1; m_rise = 0; m_fall = 0; m_err = 0;
    rst_ni = 1'b0; run_i = 0; hold_i = 0; tmo_en_i = 0; scl_i = 1;
    lo_div_i = '0; hi_div_i = '0; tmo_lim_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_pd_o, 0, "R1 pd");
    chk(rise_stb_o | mid_stb_o | fall_stb_o, 0, "R1 strobes");
    chk(stall_err_o, 0, "R1 err");
    chk(scl_low_o, 0, "R1 flag");
    @(negedge clk);
    rst_ni = 1'b1;
    apply_step();
    repeat (3) cyc();

    // R3 low length, R4 high length
    g_run = 1;
    for (int i = 0; i < 40 && !fall_stb_o; i++) cyc();
    repeat (2) cyc();
    chk(scl_pd_o, 1, "R3 low phase still pulling");
    cyc();
    chk(scl_pd_o, 0, "R3 low phase released on time");
    for (int i = 0; i < 40 && !rise_stb_o; i++) cyc();
    repeat (4) cyc();
    chk(fall_stb_o, 0, "R4 high phase not yet over");
    cyc();
    chk(fall_stb_o, 1, "R4 high phase length");

    // R4 stretch, R2 sync latency
    g_ext = 1;
    prev = 0;
    for (int i = 0; i < 60; i++) begin
      prev = scl_pd_o;
      cyc();
      if (prev && !scl_pd_o) break;
    end
    repeat (10) cyc();
    chk(rise_stb_o | scl_pd_o, 0, "R4 stalled while held");
    chk(scl_low_o, 1, "R7 flag during stretch");
    chk(stall_err_o, 0, "R4 stretch is no error");
    g_hi = 20;
    g_ext = 0;
    cyc();
    cyc(); chk(rise_stb_o, 0, "R2 no rise after 1 edge");
    cyc(); chk(rise_stb_o, 0, "R2 no rise after 2 edges");
    cyc(); chk(rise_stb_o, 1, "R2 rise after 3 edges");

    // R6 early low cuts high phase
    repeat (2) cyc();
    g_ext = 1;
    cyc();
    g_ext = 0;
    cyc();
    cyc(); chk(fall_stb_o, 0, "R6 not before sync");
    cyc(); chk(fall_stb_o, 1, "R6 early low ends high phase");

    // R8 local hold
    g_hi = 3; g_lo = 2; g_hold = 1;
    repeat (8) cyc();
    chk(scl_pd_o, 1, "R8 held low");
    chk(scl_low_o, 1, "R8 flag while held");
    g_hold = 0;
    repeat (10) cyc();

    // R9 stop
    g_run = 0;
    repeat (40) cyc();
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk(scl_pd_o | fall_stb_o, 0, "R9 idle released");
    end

    // R10 timeout, R11 clear
    g_ten = 1; g_lim = 10; g_ext = 1;
    repeat (8) cyc();
    chk(stall_err_o, 0, "R10 not before limit");
    repeat (12) cyc();
    chk(stall_err_o, 1, "R10 error after limit");
    g_ext = 0;
    repeat (10) cyc();
    chk(stall_err_o, 1, "R10 sticky");
    g_run = 1;
    cyc();
    cyc();
    chk(stall_err_o, 0, "R11 cleared on run start");

    // random phase
    rnd_ext = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 50 == 0) g_run = ~g_run;
      if ($urandom % 30 == 0) g_hold = ($urandom % 3 == 0);
      if ($urandom % 100 == 0) begin
        g_lo = $urandom % 6; g_hi = $urandom % 6;
      end
      if ($urandom % 200 == 0) begin
        g_ten = ($urandom % 4 != 0); g_lim = $urandom % 12;
      end
      cyc();
    end
    rnd_ext = 0; g_ext = 0;
    repeat (5) cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule